// File: doc/BRIEF.md
# DMA Transaction Request Collector

This block gathers per-channel transaction requests for a multi-channel DMA controller and presents one pending-request line per channel side to the channel engine. Every channel has a source side and a destination side. Each side is configured independently as software-requested (a bit in a register that software sets and the hardware clears), hardware-requested (a dedicated request line from the peripheral, synchronised inside the block), or memory (no handshaking at all, so the request is present whenever the channel is enabled).

Software sets request bits through a small register write/read port. The engine pulses a per-side completion strobe when a chunk transaction finishes, which clears the matching bit. A second register holds last-transaction flags. A flag reaches the engine only on a software-requested side whose peripheral controls the flow. A memory side can never control the flow.

Top module: `xfer_req_hub`

## Requirements
- R1: After reset every chunk-request bit and every last-transaction flag is 0, so with all channels disabled both `pend_req` and `pend_last` are 0.
- R2: A register write to offset 0 with 1 in bit 2x sets the source request of channel x, and 1 in bit 2x+1 sets its destination request, from the next clock edge. A 0 in a bit leaves that bit unchanged.
- R3: A pulse on `cmp_done[i]` clears request bit i at the next clock edge.
- R4: If a write setting bit i and `cmp_done[i]` occur in the same cycle, bit i ends up 0.
- R5: A write of 1 is ignored, and the bit stays as it was, when the side's channel is disabled, when its hardware select is 1, or when the side is marked memory.
- R6: For a side in hardware mode (`side_hw_sel`=1, `side_is_mem`=0), `pend_req` equals the peripheral request delayed by two clock edges, ANDed with the channel enable.
- R7: For a memory side (`side_is_mem`=1, which overrides the hardware select), `pend_req` equals the channel enable, whatever the request inputs and register bits hold.
- R8: `pend_last[i]` equals last-transaction flag i only when `side_flowctl[i]`=1, `side_is_mem[i]`=0 and `side_hw_sel[i]`=0. Otherwise it is 0.
- R9: A read at offset 0 returns the request bits in bits 7:0 and zeros above them. Offset 1 returns the last-transaction flags the same way and is written whole by a write there. Any other offset reads 0 and ignores writes.
- R10: For a software side (`side_hw_sel`=0, `side_is_mem`=0), `pend_req` equals its request bit ANDed with the channel enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Register offset for writes and reads |
| reg_wdata | input | 2*NUM_CH (8) | Write data, one bit per side |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| ch_en | input | NUM_CH (4) | Channel enable |
| side_hw_sel | input | 2*NUM_CH (8) | Per side: 1 selects the hardware request line, 0 the software bit |
| side_is_mem | input | 2*NUM_CH (8) | Per side: memory, no handshaking |
| side_flowctl | input | 2*NUM_CH (8) | Per side: the peripheral controls the flow |
| periph_req | input | 2*NUM_CH (8) | Asynchronous peripheral request lines |
| cmp_done | input | 2*NUM_CH (8) | Chunk-complete strobes from the engine |
| pend_req | output | 2*NUM_CH (8) | Pending request per side |
| pend_last | output | 2*NUM_CH (8) | Last-transaction flag per side after masking |

## Verification
The bench builds the block with its defaults: four channels, two synchroniser stages, a 32-bit read bus and a 2-bit offset. Eight sides are enough to hold software, hardware and memory sides, and enabled and disabled channels, side by side in one configuration. The 2-bit offset leaves two unmapped offsets, so writes and reads there can be tried. Two synchroniser stages give a fixed latency that the reference model mirrors when it compares outputs on every clock.

// File: rtl/xrh_pkg.sv
package xrh_pkg;

   // register offsets; the channel bit order 2x / 2x+1 is fixed by the engine
   localparam int unsigned XRH_OFS_CREQ = 0;
   localparam int unsigned XRH_OFS_LAST = 1;

   typedef enum logic [1:0] {
      SIDE_SW  = 2'd0,
      SIDE_HW  = 2'd1,
      SIDE_MEM = 2'd2
   } side_kind_e;

   // memory marking overrides the hardware select
   function automatic side_kind_e side_kind(input logic hw_sel, input logic is_mem);
      if (is_mem)      return SIDE_MEM;
      else if (hw_sel) return SIDE_HW;
      else             return SIDE_SW;
   endfunction

endpackage

// File: rtl/xrh_sync.sv
module xrh_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xrh_creq_bank.sv
module xrh_creq_bank #(
   parameter int unsigned SIDES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [SIDES-1:0] wbits,
   input  logic [SIDES-1:0] may_set,
   input  logic [SIDES-1:0] done,
   output logic [SIDES-1:0] q
);

   logic [SIDES-1:0] set_v;
   logic [SIDES-1:0] nxt;

   always_comb begin
      set_v = wr_hit ? (wbits & may_set) : '0;
      // completion dominates a simultaneous set
      nxt   = (q | set_v) & ~done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/xrh_side_sel.sv
module xrh_side_sel
   import xrh_pkg::*;
#(
   parameter int unsigned SIDES = 8
) (
   input  logic [SIDES-1:0] side_en,
   input  logic [SIDES-1:0] hw_sel,
   input  logic [SIDES-1:0] is_mem,
   input  logic [SIDES-1:0] flowctl,
   input  logic [SIDES-1:0] sw_bit,
   input  logic [SIDES-1:0] hw_bit,
   input  logic [SIDES-1:0] last_bit,
   output logic [SIDES-1:0] req_o,
   output logic [SIDES-1:0] last_o
);

   for (genvar i = 0; i < SIDES; i++) begin : g_side
      side_kind_e kind;
      assign kind = side_kind(hw_sel[i], is_mem[i]);

      always_comb begin
         unique case (kind)
            SIDE_MEM: req_o[i] = side_en[i];
            SIDE_HW:  req_o[i] = side_en[i] & hw_bit[i];
            default:  req_o[i] = side_en[i] & sw_bit[i];
         endcase
         last_o[i] = (kind == SIDE_SW) & flowctl[i] & last_bit[i];
      end
   end

endmodule

// File: rtl/xfer_req_hub.sv
module xfer_req_hub
   import xrh_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SIDES      = 2 * NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [SIDES-1:0]  reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [SIDES-1:0]  side_hw_sel,
   input  logic [SIDES-1:0]  side_is_mem,
   input  logic [SIDES-1:0]  side_flowctl,
   input  logic [SIDES-1:0]  periph_req,
   input  logic [SIDES-1:0]  cmp_done,
   output logic [SIDES-1:0]  pend_req,
   output logic [SIDES-1:0]  pend_last
);

   // elaboration-time parameter checks
   if (NUM_CH < 1)        begin : g_bad_ch   $error("NUM_CH must be at least 1");        end
   if (ADDR_W < 1)        begin : g_bad_aw   $error("ADDR_W must be at least 1");        end
   if (DATA_W < SIDES)    begin : g_bad_dw   $error("DATA_W must cover 2*NUM_CH bits");  end
   if (SYNC_STAGES < 2)   begin : g_bad_sync $error("SYNC_STAGES must be at least 2");   end

   localparam logic [ADDR_W-1:0] OFS_CREQ = ADDR_W'(XRH_OFS_CREQ);
   localparam logic [ADDR_W-1:0] OFS_LAST = ADDR_W'(XRH_OFS_LAST);

   logic [SIDES-1:0] side_en;
   logic [SIDES-1:0] may_set;
   logic [SIDES-1:0] creq_q;
   logic [SIDES-1:0] last_q;
   logic [SIDES-1:0] hw_sync;
   logic             wr_creq;
   logic             wr_last;

   for (genvar i = 0; i < SIDES; i++) begin : g_en
      assign side_en[i] = ch_en[i/2];
      assign may_set[i] = ch_en[i/2] & ~side_hw_sel[i] & ~side_is_mem[i];
   end

   assign wr_creq = reg_wr && (reg_addr == OFS_CREQ);
   assign wr_last = reg_wr && (reg_addr == OFS_LAST);

   xrh_sync #(
      .WIDTH  (SIDES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (periph_req),
      .q     (hw_sync)
   );

   xrh_creq_bank #(
      .SIDES (SIDES)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_creq),
      .wbits   (reg_wdata),
      .may_set (may_set),
      .done    (cmp_done),
      .q       (creq_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q <= '0;
      else if (wr_last) last_q <= reg_wdata;
   end

   xrh_side_sel #(
      .SIDES (SIDES)
   ) u_sel (
      .side_en  (side_en),
      .hw_sel   (side_hw_sel),
      .is_mem   (side_is_mem),
      .flowctl  (side_flowctl),
      .sw_bit   (creq_q),
      .hw_bit   (hw_sync),
      .last_bit (last_q),
      .req_o    (pend_req),
      .last_o   (pend_last)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_CREQ)      reg_rdata[SIDES-1:0] = creq_q;
      else if (reg_addr == OFS_LAST) reg_rdata[SIDES-1:0] = last_q;
   end

endmodule

// File: rtl/xrh_chk.sv
module xrh_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 2,
   localparam int unsigned SIDES = 2 * NUM_CH
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [SIDES-1:0]  reg_wdata,
   input logic [NUM_CH-1:0] ch_en,
   input logic [SIDES-1:0]  side_hw_sel,
   input logic [SIDES-1:0]  side_is_mem,
   input logic [SIDES-1:0]  side_flowctl,
   input logic [SIDES-1:0]  cmp_done,
   input logic [SIDES-1:0]  creq_q,
   input logic [SIDES-1:0]  pend_req,
   input logic [SIDES-1:0]  pend_last
);

   logic [SIDES-1:0] en_c;
   logic [SIDES-1:0] accept_c;
   logic             creq_wr_c;

   always_comb begin
      for (int i = 0; i < SIDES; i++) en_c[i] = ch_en[i/2];
      creq_wr_c = reg_wr && (reg_addr == '0);
      accept_c  = reg_wdata & en_c & ~side_hw_sel & ~side_is_mem & ~cmp_done;
   end

   a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
      creq_wr_c |=> ((creq_q & $past(accept_c)) == $past(accept_c)));

   a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_done != '0) |=> ((creq_q & $past(cmp_done)) == '0));

   a_r5_no_set_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !creq_wr_c |=> ((creq_q & ~$past(creq_q)) == '0));

   a_r5_no_set_on_hw_or_mem: assert property (@(posedge clk) disable iff (!rst_n)
      creq_wr_c |=> ((creq_q & ~$past(creq_q) & ($past(side_hw_sel) | $past(side_is_mem))) == '0));

   a_r7_mem_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_req & side_is_mem) == (en_c & side_is_mem)));

   a_r8_last_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_last & (~side_flowctl | side_is_mem | side_hw_sel)) == '0));

endmodule

bind xfer_req_hub xrh_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .ch_en        (ch_en),
   .side_hw_sel  (side_hw_sel),
   .side_is_mem  (side_is_mem),
   .side_flowctl (side_flowctl),
   .cmp_done     (cmp_done),
   .creq_q       (creq_q),
   .pend_req     (pend_req),
   .pend_last    (pend_last)
);

// File: tb/xfer_req_hub_test.sv
module xfer_req_hub_test;

   localparam int NCH = 4;
   localparam int NS  = 2 * NCH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [NS-1:0] reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NCH-1:0] ch_en = '0;
   logic [NS-1:0] side_hw_sel = '0;
   logic [NS-1:0] side_is_mem = '0;
   logic [NS-1:0] side_flowctl = '0;
   logic [NS-1:0] periph_req = '0;
   logic [NS-1:0] cmp_done = '0;
   logic [NS-1:0] pend_req;
   logic [NS-1:0] pend_last;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #4 clk = ~clk;   // 125 MHz

   xfer_req_hub uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_en(ch_en),
      .side_hw_sel(side_hw_sel), .side_is_mem(side_is_mem),
      .side_flowctl(side_flowctl), .periph_req(periph_req),
      .cmp_done(cmp_done), .pend_req(pend_req), .pend_last(pend_last)
   );

   // ---------------- behavioural reference model ----------------
   bit m_req [NS];
   bit m_last[NS];
   bit m_s1  [NS];
   bit m_s2  [NS];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_req[i] <= 0; m_last[i] <= 0; m_s1[i] <= 0; m_s2[i] <= 0;
         end
      end else begin
         for (int i = 0; i < NS; i++) begin
            bit allowed;
            allowed = ch_en[i/2] && !side_hw_sel[i] && !side_is_mem[i];
            m_s2[i] <= m_s1[i];
            m_s1[i] <= periph_req[i];
            if (cmp_done[i])
               m_req[i] <= 0;
            else if (reg_wr && reg_addr == 2'd0 && reg_wdata[i] && allowed)
               m_req[i] <= 1;
            if (reg_wr && reg_addr == 2'd1) m_last[i] <= reg_wdata[i];
         end
      end
   end

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int i = 0; i < NS; i++) begin
            bit en, er, el;
            en = ch_en[i/2];
            if (side_is_mem[i]) begin
               er = en;
               check($sformatf("R7 pend_req side %0d", i), pend_req[i], er);
            end else if (side_hw_sel[i]) begin
               er = en && m_s2[i];
               check($sformatf("R6 pend_req side %0d", i), pend_req[i], er);
            end else begin
               er = en && m_req[i];
               check($sformatf("R10 pend_req side %0d", i), pend_req[i], er);
            end
            el = m_last[i] && side_flowctl[i] && !side_is_mem[i] && !side_hw_sel[i];
            check($sformatf("R8 pend_last side %0d", i), pend_last[i], el);
         end
         begin
            longint er_data;
            er_data = 0;
            for (int i = 0; i < NS; i++) begin
               if (reg_addr == 2'd0 && m_req[i])  er_data |= (64'd1 << i);
               if (reg_addr == 2'd1 && m_last[i]) er_data |= (64'd1 << i);
            end
            check($sformatf("R9 read offset %0d", reg_addr), reg_rdata, er_data);
         end
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [NS-1:0] d, input logic [NS-1:0] dn);
      reg_wr = 1; reg_addr = a; reg_wdata = d; cmp_done = dn;
      step();
      reg_wr = 0; reg_wdata = '0; cmp_done = '0;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 50000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      @(negedge clk);
      check("R1 reset request register", reg_rdata, 0);
      check("R1 reset pend_req", pend_req, 0);
      check("R1 reset pend_last", pend_last, 0);

      // ch0 both software, ch1 source hardware, ch2 source memory, ch3 disabled
      ch_en = 4'b0111;
      side_hw_sel = 8'b0000_0100;
      side_is_mem = 8'b0001_0000;
      side_flowctl = 8'b0011_0011;
      step();
      wr(2'd0, 8'hFF, 8'h00);
      reg_addr = 2'd0;
      @(negedge clk);
      check("R2 R5 set only on enabled software sides", reg_rdata, 32'h2B);

      step();
      wr(2'd0, 8'h00, 8'h00);
      @(negedge clk);
      check("R2 zero write leaves bits", reg_rdata, 32'h2B);

      step();
      wr(2'd0, 8'h00, 8'h01);
      @(negedge clk);
      check("R3 completion clears bit 0", reg_rdata, 32'h2A);

      step();
      wr(2'd0, 8'h02, 8'h02);
      @(negedge clk);
      check("R4 completion wins over write", reg_rdata, 32'h28);

      step();
      wr(2'd1, 8'hFF, 8'h00);
      reg_addr = 2'd1;
      @(negedge clk);
      check("R9 last register readback", reg_rdata, 32'hFF);
      check("R8 masked last flags", pend_last, 8'h23);
      check("R7 memory side enabled", pend_req[4], 1);

      step();
      ch_en = 4'b0011;
      @(negedge clk);
      check("R7 memory side follows disable", pend_req[4], 0);

      step();
      ch_en = 4'b0111;
      periph_req = 8'h04;
      step();
      @(negedge clk);
      check("R6 one edge not yet visible", pend_req[2], 0);
      step();
      @(negedge clk);
      check("R6 visible after two edges", pend_req[2], 1);

      step();
      wr(2'd2, 8'hFF, 8'h00);
      reg_addr = 2'd2;
      @(negedge clk);
      check("R9 unmapped offset reads zero", reg_rdata, 0);
      reg_addr = 2'd0;
      @(posedge clk); #1;
      @(negedge clk);
      check("R9 unmapped write no effect", reg_rdata, 32'h28);

      // random phase, compared against the model every clock
      for (int n = 0; n < 2000; n++) begin
         step();
         periph_req = NS'($urandom);
         reg_wr     = ($urandom % 3) == 0;
         reg_addr   = 2'($urandom);
         reg_wdata  = NS'($urandom);
         cmp_done   = NS'($urandom) & NS'($urandom);
         if ((n % 97) == 0) begin
            ch_en        = NCH'($urandom);
            side_hw_sel  = NS'($urandom);
            side_is_mem  = NS'($urandom) & NS'($urandom);
            side_flowctl = NS'($urandom);
         end
      end
      step();
      reg_wr = 0; cmp_done = '0;
      @(negedge clk);
      finish_run();
   end

endmodule